// File: doc/BRIEF.md
# Modulo-17 Gray-Sequence Counter

This block is a synchronous five-bit counter that walks through exactly seventeen codes and then starts over. Sixteen of the codes form a four-bit reflected Gray sequence in the low bits with the top bit clear. The seventeenth code, 11000, sets the top bit. So every step but one changes a single bit, and the return from 11000 to 00000 changes two.

The top bit doubles as the terminal-count output. With the advance enable held high, it rises for one clock period in every seventeen, which lets a designer divide an event stream by seventeen. The next-state logic is purely combinational. Each of the five bits has its own sum-of-products function. Each product term is one full match against a legal code, so any code outside the sequence produces 00000 at the next enabled edge.

Top module: `g17_counter`

## Requirements
- R1: A high `rst` at a rising clock edge loads 00000 into `state_q`, whatever `adv_en` is at that edge.
- R2: With `adv_en` high at each rising edge and starting from 00000, `state_q` shows, edge by edge, 00000, 00001, 00011, 00010, 00110, 00111, 00101, 00100, 01100, 01101, 01111, 01110, 01010, 01011, 01001, 01000, 11000 and then 00000 again (bit 4 is the most significant bit).
- R3: Each enabled step from a legal code other than 11000 changes exactly one bit of `state_q`. The step from 11000 to 00000 changes two bits.
- R4: When `adv_en` is low at a rising edge and `rst` is low, `state_q` keeps its value.
- R5: The fifteen illegal codes are those with bit 4 set, except 11000. From any of them, `state_q` is 00000 after the next enabled edge, and it holds while `adv_en` is low.
- R6: `tc_q` equals bit 4 of the registered state. It is high only in code 11000, so with `adv_en` held high it is high for exactly one period in every seventeen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 00000 |
| adv_en | input | 1 | Advance enable; the state steps at an edge only when this is high |
| state_q | output | 5 | Registered current code, bit 4 most significant |
| tc_q | output | 1 | Terminal-count flag, high in code 11000 |

## Verification
Both outputs come straight from the state register, so the effect of `rst` or `adv_en` sampled at a rising edge is visible one edge later and never before. The bench changes inputs only on falling edges and reads `state_q` and `tc_q` at the next falling edge. Each of its reads therefore lands half a period after the edge that produced the result. A bench reference model advances once per edge by looking the code up in a literal seventeen-entry table. Illegal codes are placed into the state register between edges, and recovery is expected exactly one enabled edge later.

// File: rtl/g17_pkg.sv
package g17_pkg;

  // Code width and sequence length of the counter.
  localparam int G17_W     = 5;
  localparam int G17_MOD   = 17;
  localparam int G17_LOW_W = G17_W - 1;

  typedef logic [G17_W-1:0] g17_code_t;

  // Reflected binary code of n, truncated to the code width.
  function automatic g17_code_t g17_gray(int unsigned n);
    g17_code_t b;
    b = g17_code_t'(n);
    return b ^ (b >> 1);
  endfunction

  // Code held at sequence position k (0 .. G17_MOD-1).
  // Positions below G17_MOD-1 are plain Gray codes with the top bit clear.
  // The last position repeats the low bits of its predecessor with the top bit set.
  function automatic g17_code_t g17_code_at(int unsigned k);
    g17_code_t prev;
    if (k < G17_MOD - 1) begin
      return g17_gray(k);
    end
    prev = g17_gray(k - 1);
    return {1'b1, prev[G17_LOW_W-1:0]};
  endfunction

  // Sequence position that follows position k.
  function automatic int unsigned g17_succ(int unsigned k);
    return (k == G17_MOD - 1) ? 0 : k + 1;
  endfunction

endpackage

// File: rtl/g17_decode.sv
module g17_decode
  import g17_pkg::*;
#(
  parameter int W   = G17_W,
  parameter int MOD = G17_MOD
) (
  input  logic [W-1:0]   cur,
  output logic [MOD-1:0] hit
);

  // One full-width comparator per legal code: these are the product terms.
  for (genvar k = 0; k < MOD; k++) begin : g_match
    localparam logic [W-1:0] CODE_K = W'(g17_code_at(k));
    assign hit[k] = (cur == CODE_K);
  end

endmodule

// File: rtl/g17_next.sv
module g17_next
  import g17_pkg::*;
#(
  parameter int W   = G17_W,
  parameter int MOD = G17_MOD
) (
  input  logic [MOD-1:0] hit,
  output logic [W-1:0]   nxt
);

  // Per output bit: OR of those matched states whose successor sets that bit.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [MOD-1:0] term;
    for (genvar k = 0; k < MOD; k++) begin : g_term
      localparam logic [W-1:0] SUCC_K = W'(g17_code_at(g17_succ(k)));
      assign term[k] = hit[k] & SUCC_K[b];
    end
    assign nxt[b] = |term;
  end

endmodule

// File: rtl/g17_state_reg.sv
module g17_state_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (en) begin
      st_q <= d;
    end
  end

  assign q = st_q;

endmodule

// File: rtl/g17_counter.sv
module g17_counter
  import g17_pkg::*;
#(
  parameter int W   = G17_W,
  parameter int MOD = G17_MOD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  output logic [W-1:0] state_q,
  output logic         tc_q
);

  logic [MOD-1:0] hit_w;    // one-hot match of the current code
  logic [W-1:0]   next_w;   // combinational successor
  logic           legal_w;  // current code is in the sequence
  logic           wrap_w;   // current code is the last of the sequence

  g17_decode #(.W(W), .MOD(MOD)) u_dec (
    .cur (state_q),
    .hit (hit_w)
  );

  g17_next #(.W(W), .MOD(MOD)) u_nxt (
    .hit (hit_w),
    .nxt (next_w)
  );

  g17_state_reg #(.W(W)) u_state (
    .clk (clk),
    .rst (rst),
    .en  (adv_en),
    .d   (next_w),
    .q   (state_q)
  );

  assign legal_w = |hit_w;
  assign wrap_w  = hit_w[MOD-1];
  assign tc_q    = state_q[W-1];

endmodule

// File: rtl/g17_counter_chk.sv
module g17_counter_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         adv_en,
  input logic [W-1:0] state_q,
  input logic         tc_q,
  input logic         legal_w,
  input logic         wrap_w
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (state_q == '0));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (adv_en && wrap_w) |=> (state_q == '0));

  assert_single_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && legal_w && !wrap_w) |=> ($countones(state_q ^ $past(state_q)) == 1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(state_q));

  assert_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !legal_w) |=> (state_q == '0));

  assert_legal_set_R5: assert property (@(posedge clk) disable iff (rst)
    legal_w == (!state_q[W-1] || (state_q == {2'b11, {(W-2){1'b0}}})));

  assert_tc_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (tc_q && adv_en) |=> !tc_q);

endmodule

bind g17_counter g17_counter_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .adv_en  (adv_en),
  .state_q (state_q),
  .tc_q    (tc_q),
  .legal_w (legal_w),
  .wrap_w  (wrap_w)
);

// File: tb/sim_g17_counter.sv
module sim_g17_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv_en = 1'b0;
  logic [4:0] state_q;
  logic       tc_q;
  logic [4:0] model = 5'b0;
  int         tests = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  g17_counter u0 (
    .clk     (clk),
    .rst     (rst),
    .adv_en  (adv_en),
    .state_q (state_q),
    .tc_q    (tc_q)
  );

  // Sequence as listed in R2.
  function automatic logic [4:0] seq_tbl(int k);
    case (k)
      0: return 5'b00000;   1: return 5'b00001;   2: return 5'b00011;
      3: return 5'b00010;   4: return 5'b00110;   5: return 5'b00111;
      6: return 5'b00101;   7: return 5'b00100;   8: return 5'b01100;
      9: return 5'b01101;  10: return 5'b01111;  11: return 5'b01110;
     12: return 5'b01010;  13: return 5'b01011;  14: return 5'b01001;
     15: return 5'b01000;  16: return 5'b11000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] ref_next(logic [4:0] s);
    for (int k = 0; k < 17; k++) begin
      if (seq_tbl(k) == s) return seq_tbl((k + 1) % 17);
    end
    return 5'b00000;   // R5: any code outside the table
  endfunction

  task automatic chk(string req, string what, logic [4:0] act, logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, return at the next falling edge.
  task automatic cycle(bit r, bit e);
    rst = r;
    adv_en = e;
    @(posedge clk);
    if (r) model = 5'b0;
    else if (e) model = ref_next(model);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int tc_hits;
    int unsigned seed;
    logic [4:0] prev;
    seed = 32'h0017_5eed;
    void'($urandom(seed));
    @(negedge clk);

    // R1: reset state
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    chk("R1", "reset state", state_q, 5'b00000);
    chk("R6", "tc after reset", {4'b0, tc_q}, 5'b0);

    // R2, R3: full sequence plus the wrap
    for (int k = 1; k <= 17; k++) begin
      prev = state_q;
      cycle(1'b0, 1'b1);
      chk("R2", $sformatf("step %0d", k), state_q, seq_tbl(k % 17));
      if (k < 17) chk("R3", "one bit flips", 5'($countones(prev ^ state_q)), 5'd1);
      else        chk("R3", "wrap flips two bits", prev ^ state_q, 5'b11000);
    end

    // R4: hold with the enable low
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1);
    prev = state_q;
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0);
      chk("R4", "hold", state_q, prev);
    end

    // R1: reset wins over the enable
    cycle(1'b1, 1'b1);
    chk("R1", "reset beats enable", state_q, 5'b00000);

    // R6: one terminal pulse per 17 enabled periods
    tc_hits = 0;
    for (int k = 0; k < 34; k++) begin
      cycle(1'b0, 1'b1);
      if (tc_q) tc_hits++;
      chk("R6", "tc equals top bit of expected code", {4'b0, tc_q}, {4'b0, model[4]});
    end
    chk("R6", "tc pulses in 34 periods", 5'(tc_hits), 5'd2);

    // R5: every illegal code recovers to 00000
    for (int c = 16; c < 32; c++) begin
      if (c == 24) continue;
      $assertoff;
      force u0.u_state.st_q = 5'(c);
      #1;
      release u0.u_state.st_q;
      #1;
      chk("R5", "illegal code loaded", state_q, 5'(c));
      model = 5'(c);
      cycle(1'b0, 1'b0);
      chk("R5", "illegal code held with enable low", state_q, 5'(c));
      cycle(1'b0, 1'b1);
      chk("R5", "illegal code recovers", state_q, 5'b00000);
      $asserton;
    end

    // R2 under random enable and reset
    for (int k = 0; k < 3000; k++) begin
      cycle(($urandom % 64) == 0, ($urandom % 4) != 0);
      chk("R2", "random run", state_q, model);
      chk("R6", "random tc", {4'b0, tc_q}, {4'b0, model[4]});
    end

    summary();
  end

endmodule